// File: doc/BRIEF.md
# Branch Redirect and Squash Controller

This block governs the flow of instructions through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose fetch runs ahead speculatively along the sequential path. It holds the fetch address and, for each stage, a valid bit and an address tag that move forward one stage every cycle in which the pipeline advances.

A later stage, EX by default and chosen by a parameter, reports the outcome and target of the branch it holds. When that branch is taken, the block loads the target as the next fetch address. Every younger slot becomes a bubble. Bubbles keep travelling down the pipeline in step with real instructions, so a wrong-path instruction can never raise the writeback write enable. The number of squashed slots equals the index of the resolve stage: two for EX and one for ID.

Top module: `branch_flush_ctrl`

## Requirements
- R1: While reset is held and right after it, fetch_pc equals RESET_VEC, every stage_valid bit is 0, and wb_we is 0.
- R2: stage_valid bit 0 is the fetch slot and bit 4 is writeback. The first advance after reset makes the fetch slot valid at RESET_VEC. Each later advance without a redirect fetches the current fetch_pc plus 4.
- R3: While advance is 0, fetch_pc, stage_valid and wb_pc hold their values and wb_we is 0. Branch inputs offered in such a cycle have no effect.
- R4: A branch is taken when, in an advancing cycle, br_valid and br_taken are both 1 and stage_valid bit RESOLVE_STG is 1. In the following cycle fetch_pc equals br_target and stage_valid bit 0 is 1. This replaces the sequential address.
- R5: After a taken branch, stage_valid bits 1 up to RESOLVE_STG are 0, so exactly RESOLVE_STG younger slots are squashed (two by default). The branch itself moves on valid to bit RESOLVE_STG+1.
- R6: Branch inputs have no effect when br_taken is 0, when br_valid is 0, or when stage_valid bit RESOLVE_STG is 0. In those cases the fetch address steps sequentially.
- R7: On every advance, each stage takes the valid bit and address tag of the stage before it, except where R5 squashes. A bubble therefore reaches writeback after the same number of advances as an instruction would, and wb_pc is the address that was fetched four advances earlier.
- R8: wb_we is 1 exactly when advance is 1 and stage_valid bit 4 is 1, so no squashed slot ever produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| advance | input | 1 | Pipeline moves one stage this cycle |
| br_valid | input | 1 | Resolve stage reports a branch outcome |
| br_taken | input | 1 | Reported branch is taken |
| br_target | input | PC_W | Redirect address for a taken branch |
| fetch_pc | output | PC_W | Address fetched this cycle |
| stage_valid | output | 5 | Per-stage valid bits, bit 0 fetch to bit 4 writeback |
| wb_pc | output | PC_W | Address tag of the writeback slot |
| wb_we | output | 1 | Gated architectural write enable |

## Verification
Directed runs after reset walk the pipeline fill and then place one taken branch in EX. This separates the fetch of the reset vector from sequential stepping and shows the exact two-slot hole in the valid bits. Random runs mix stalls, not-taken outcomes, and outcomes offered while the EX slot is a bubble. These cases separate a real redirect from branch inputs that must be ignored. They also show that bubbles hold their place through stalls and never produce a writeback write. A reference model in the bench predicts every output on every cycle.

// File: rtl/branch_flush_ctrl.sv
module branch_flush_ctrl #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000,
  parameter int INSTR_BYTES = 4,
  parameter int RESOLVE_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            br_valid,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] fetch_pc,
  output logic [4:0]      stage_valid,
  output logic [PC_W-1:0] wb_pc,
  output logic            wb_we
);
  localparam int NSTG = 5;
  localparam int WB = NSTG - 1;
  localparam logic [NSTG-1:0] SQ_MASK = NSTG'((1 << (RESOLVE_STG + 1)) - 2);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [NSTG-1:0] sval;
  logic [PC_W-1:0] spc [NSTG];
  logic take;

  assign take        = advance & br_valid & br_taken & sval[RESOLVE_STG];
  assign fetch_pc    = spc[0];
  assign stage_valid = sval;
  assign wb_pc       = spc[WB];
  assign wb_we       = advance & sval[WB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sval <= '0;
      for (int s = 0; s < NSTG; s++) spc[s] <= (s == 0) ? RESET_VEC : '0;
    end else if (advance) begin
      sval[0] <= 1'b1;
      if (take)         spc[0] <= br_target;
      else if (sval[0]) spc[0] <= spc[0] + STEP;
      for (int s = 1; s < NSTG; s++) begin
        sval[s] <= sval[s-1] & ~(take && s <= RESOLVE_STG);
        spc[s]  <= spc[s-1];
      end
    end
  end

  a_r1_reset: assert property (@(posedge clk) !rst_n |=> stage_valid == '0 && fetch_pc == RESET_VEC);
  a_r2_seq: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !take && stage_valid[0] |=> fetch_pc == $past(fetch_pc) + STEP);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(stage_valid) && $stable(fetch_pc) && $stable(wb_pc));
  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> fetch_pc == $past(br_target) && stage_valid[0]);
  a_r5_squash: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (stage_valid & SQ_MASK) == '0 && stage_valid[RESOLVE_STG+1]);
  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !stage_valid[RESOLVE_STG] && stage_valid[0] |=> fetch_pc == $past(fetch_pc) + STEP);
  a_r8_we: assert property (@(posedge clk) disable iff (!rst_n) wb_we |-> stage_valid[WB]);

  for (genvar g = RESOLVE_STG + 1; g < NSTG; g++) begin : g_shift
    a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> stage_valid[g] == $past(stage_valid[g-1]));
  end
endmodule

// File: tb/tb_branch_flush_ctrl.sv
`timescale 1ns/1ps
module tb_branch_flush_ctrl;
  localparam int PC_W = 32;
  localparam logic [31:0] RV = 32'h0000_1000;
  localparam int RS = 2;

  logic clk = 0, rst_n = 0, advance = 0, br_valid = 0, br_taken = 0;
  logic [PC_W-1:0] br_target = '0;
  logic [PC_W-1:0] fetch_pc, wb_pc;
  logic [4:0] stage_valid;
  logic wb_we;

  int checks = 0, failures = 0;
  bit mv [5];
  logic [31:0] mp [5];

  always #2.5 clk = ~clk;

  branch_flush_ctrl #(.PC_W(PC_W), .RESET_VEC(RV), .RESOLVE_STG(RS)) dut (
    .clk, .rst_n, .advance, .br_valid, .br_taken, .br_target,
    .fetch_pc, .stage_valid, .wb_pc, .wb_we);

  function automatic logic [4:0] mvec();
    logic [4:0] v;
    for (int s = 0; s < 5; s++) v[s] = mv[s];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 5; s++) begin mv[s] = 0; mp[s] = '0; end
    mp[0] = RV;
  endtask

  task automatic model_step();
    bit tk;
    if (!advance) return;
    tk = br_valid && br_taken && mv[RS];
    for (int s = 4; s >= 1; s--) begin
      mv[s] = mv[s-1] && !(tk && s <= RS);
      mp[s] = mp[s-1];
    end
    if (tk) mp[0] = br_target;
    else if (mv[0]) mp[0] = mp[0] + 4;
    mv[0] = 1;
  endtask

  task automatic check_regs(string tag);
    chk({"R2/R4 fetch_pc ", tag}, fetch_pc, mp[0]);
    chk({"R5/R7 stage_valid ", tag}, 32'(stage_valid), 32'(mvec()));
    if (mv[4]) chk({"R7 wb_pc ", tag}, wb_pc, mp[4]);
  endtask

  task automatic cyc(bit a, bit bv, bit bt, logic [31:0] tgt);
    advance = a; br_valid = bv; br_taken = bt; br_target = tgt;
    #1;
    chk("R8 wb_we", 32'(wb_we), 32'(a && mv[4]));
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_regs("cycle");
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch_pc reset", fetch_pc, RV);
    chk("R1 valid reset", 32'(stage_valid), 0);
    chk("R1 wb_we reset", 32'(wb_we), 0);
    rst_n = 1;
    // R2 fill
    cyc(1, 0, 0, 0);
    chk("R2 first fetch at reset vector", fetch_pc, RV);
    cyc(1, 1, 1, 32'h40);  // R6: EX slot is a bubble, ignored
    chk("R6 ignored while EX empty", fetch_pc, RV + 4);
    cyc(1, 0, 0, 0);
    chk("R2 sequential", fetch_pc, RV + 8);
    chk("R7 fill", 32'(stage_valid), 32'b00111);
    cyc(0, 1, 1, 32'h80);  // R3 stall ignores branch
    chk("R3 stalled pc", fetch_pc, RV + 8);
    chk("R3 stalled valid", 32'(stage_valid), 32'b00111);
    cyc(1, 1, 1, 32'h2000);
    chk("R4 redirect", fetch_pc, 32'h2000);
    chk("R5 two-slot hole", 32'(stage_valid), 32'b01001);
    cyc(1, 1, 0, 32'h3000);  // EX now bubble anyway
    chk("R7 bubble moves", 32'(stage_valid), 32'b10011);
    chk("R7 wb tag", wb_pc, RV);
    cyc(1, 0, 0, 0);
    chk("R7 bubbles at MEM/WB", 32'(stage_valid), 32'b00111);
    cyc(1, 1, 0, 32'h5000);
    chk("R6 not taken steps", fetch_pc, 32'h200C);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] t = {$urandom} & 32'h0000_FFFC;
      cyc(($urandom % 5) != 0, ($urandom % 3) == 0, $urandom % 2, t);
      if (i == 1500) begin
        rst_n = 0;
        @(posedge clk); model_reset(); @(negedge clk);
        chk("R1 mid reset valid", 32'(stage_valid), 0);
        chk("R1 mid reset pc", fetch_pc, RV);
        rst_n = 1;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule